// File: doc/BRIEF.md
# Three-Wire Serial Control Register Slave

This block is the control port of a small sensing front end. A host reaches it over three wires: an active-high frame enable, a serial clock and one shared data line that both sides drive in turn. Each frame is sixteen serial clocks long. It carries an eight-bit address followed by eight data bits, most significant bit first. The top address bit selects the direction. For a write, the host drives all sixteen bits. For a read, the host drives only the address, and the slave then drives the register contents back on the same wire.

The slave holds a packed control register, three eight-bit gain codes and two test locations that are fixed at zero. A group-select pin places the register set at either 00h–0Fh or 10h–1Fh. From the control register and the gain codes, the block decodes the power state, the gain range, the wavelength channel and the gain code in use, and presents them as outputs.

All serial pins are sampled by a fast system clock through synchronizers. The serial clock is therefore handled as data, and all state lives in a single clock domain.

Top module: `tw_ctl_slave`

## Requirements
- R1: After reset the control register is 00h, so the power output is low, the range and channel outputs are 00 and the gain code output is 00h. Each of the three gain registers reads FFh.
- R2: A write frame has address bit 7 at 0 and exactly sixteen rising serial-clock edges while enable is high. It stores its last eight bits in the register chosen by address bits [3:0]: index 0 is control, and indices 1, 2 and 3 are the gains for channels 01, 10 and 11.
- R3: Address bit 4 must equal the group-select pin. Otherwise the frame writes nothing and the slave never drives the data line, so the same register set answers at 00h–0Fh when the pin is low and at 10h–1Fh when it is high.
- R4: A read frame has address bit 7 at 1. The slave returns the addressed register on the data line, most significant bit first. Each bit is launched on a falling serial-clock edge, so the host can sample it on rising edges 9 to 16.
- R5: The data-line driver turns on only after the eighth rising edge of a read frame in the slave's own group, and turns off once enable is low.
- R6: Indices 0Eh and 0Fh are test locations. Writes to them have no effect, and reads from them return 00h.
- R7: Indices 04h to 0Dh are reserved. Writes to them change no register, and reads from them return 00h.
- R8: A frame that ends with fewer or more than sixteen rising edges changes no register.
- R9: The power output is high only when control bits [7:6] are 11. The range output copies control bits [5:4] (01 high, 10 middle, 11 low), and the channel output copies bits [3:2]. Bits [1:0] are stored and read back unchanged.
- R10: The gain code output equals the gain register of the selected channel. It is 00h when the power output is low or when the channel field is 00.
- R11: A read frame changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| grp_sel | input | 1 | Address group select; low means 00h–0Fh, high means 10h–1Fh |
| ser_en | input | 1 | Frame enable, high for the duration of a frame |
| ser_clk | input | 1 | Serial clock from the host, idle low |
| ser_dio | inout | 1 | Shared serial data line |
| pwr_on | output | 1 | Decoded power state |
| gain_range | output | 2 | Gain range field |
| wave_ch | output | 2 | Wavelength channel field |
| gain_code | output | 8 | Gain code of the active channel, zero when inactive |

## Verification
The checks assume that the serial clock and frame enable are slow against the system clock. Each level must last many system cycles, so that every edge is seen once through the synchronizers and no rising and falling serial edge land in the same cycle. The checks also assume that the host stops driving the data line just after the eighth rising edge of a read. The stimulus keeps write half-periods at ten system cycles and read half-periods at twenty-five. It releases the host driver one system cycle after the eighth rise, which is before the slave's driver turns on, and it leaves enable low for forty cycles between frames.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    RANGE_OFF  = 2'b00,
    RANGE_HIGH = 2'b01,
    RANGE_MID  = 2'b10,
    RANGE_LOW  = 2'b11
  } range_e;

  typedef enum logic [1:0] {
    CH_OFF = 2'b00,
    CH_405 = 2'b01,
    CH_650 = 2'b10,
    CH_780 = 2'b11
  } chan_e;

  localparam logic [1:0] PWR_ACTIVE = 2'b11;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= '0;
        end else begin
          stg_q[s] <= (s == 0) ? d : stg_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/tw_frame.sv
module tw_frame #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 4,
  parameter int SEL_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_s,
  input  logic              sck_s,
  input  logic              din_s,
  input  logic              sel_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_addr,
  output logic              reg_we,
  output logic [IDX_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              dio_oe,
  output logic              dio_out
);
  localparam int FRAME_LEN = ADDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);
  localparam int RW_BIT    = ADDR_W - 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W - 1);

  logic                 en_q, sck_q;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]    out_q, out_d;
  logic                 oe_q, oe_d;
  logic                 bit_q, bit_d;
  logic                 sck_rise, sck_fall, en_fall;
  logic [ADDR_W-1:0]    addr_now;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign en_fall  = en_q & ~en_s;
  assign addr_now = {sh_q[ADDR_W-2:0], din_s};
  assign rd_addr  = addr_now[IDX_W-1:0];

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    out_d = out_q;
    oe_d  = oe_q;
    bit_d = bit_q;
    if (!en_s) begin
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      if (sck_rise) begin
        if (cnt_q != CNT_OVER) begin
          cnt_d = cnt_q + 1'b1;
        end
        sh_d = {sh_q[FRAME_LEN-2:0], din_s};
        if ((cnt_q == CNT_ADDR) && addr_now[RW_BIT] && (addr_now[SEL_BIT] == sel_s)) begin
          oe_d  = 1'b1;
          out_d = rd_data;
          bit_d = 1'b0;
        end
      end
      if (sck_fall && oe_q) begin
        bit_d = out_q[DATA_W-1];
        out_d = {out_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sck_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
      out_q <= '0;
      oe_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      en_q  <= en_s;
      sck_q <= sck_s;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      out_q <= out_d;
      oe_q  <= oe_d;
      bit_q <= bit_d;
    end
  end

  assign reg_we    = en_fall && (cnt_q == CNT_FULL) && !sh_q[FRAME_LEN-1]
                     && (sh_q[DATA_W+SEL_BIT] == sel_s);
  assign reg_addr  = sh_q[DATA_W+IDX_W-1:DATA_W];
  assign reg_wdata = sh_q[DATA_W-1:0];
  assign dio_oe    = oe_q;
  assign dio_out   = bit_q;
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  parameter int NGAIN  = 3,
  parameter logic [DATA_W-1:0] GAIN_INIT = '1,
  parameter logic [DATA_W-1:0] CTRL_INIT = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [DATA_W-1:0]       rd_data,
  output logic [DATA_W-1:0]       ctrl_q,
  output logic [NGAIN*DATA_W-1:0] gain_q
);
  logic ctrl_en;
  assign ctrl_en = we && (wr_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
    end else if (ctrl_en) begin
      ctrl_q <= wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NGAIN; g++) begin : g_gain
      logic gain_en;
      assign gain_en = we && (wr_idx == IDX_W'(g + 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          gain_q[g*DATA_W +: DATA_W] <= GAIN_INIT;
        end else if (gain_en) begin
          gain_q[g*DATA_W +: DATA_W] <= wdata;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (rd_idx == '0) begin
      rd_data = ctrl_q;
    end
    for (int i = 0; i < NGAIN; i++) begin
      if (rd_idx == IDX_W'(i + 1)) begin
        rd_data = gain_q[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/tw_decode.sv
module tw_decode
  import tw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NGAIN  = 3
) (
  input  logic [DATA_W-1:0]       ctrl_q,
  input  logic [NGAIN*DATA_W-1:0] gain_q,
  output logic                    pwr_on,
  output logic [1:0]              gain_range,
  output logic [1:0]              wave_ch,
  output logic [DATA_W-1:0]       gain_code
);
  localparam int PWR_LSB = DATA_W - 2;
  localparam int RNG_LSB = DATA_W - 4;
  localparam int CH_LSB  = DATA_W - 6;

  chan_e  ch_sel;
  range_e rng_sel;

  assign pwr_on     = (ctrl_q[PWR_LSB +: 2] == PWR_ACTIVE);
  assign rng_sel    = range_e'(ctrl_q[RNG_LSB +: 2]);
  assign ch_sel     = chan_e'(ctrl_q[CH_LSB +: 2]);
  assign gain_range = rng_sel;
  assign wave_ch    = ch_sel;

  always_comb begin
    gain_code = '0;
    if (pwr_on && (ch_sel != CH_OFF)) begin
      for (int i = 0; i < NGAIN; i++) begin
        if (ch_sel == chan_e'(i + 1)) begin
          gain_code = gain_q[i*DATA_W +: DATA_W];
        end
      end
    end
  end
endmodule

// File: rtl/tw_ctl_slave.sv
module tw_ctl_slave #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int NGAIN       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_sel,
  input  logic              ser_en,
  input  logic              ser_clk,
  inout  wire               ser_dio,
  output logic              pwr_on,
  output logic [1:0]        gain_range,
  output logic [1:0]        wave_ch,
  output logic [DATA_W-1:0] gain_code
);
  localparam int IDX_W   = 4;
  localparam int SEL_BIT = IDX_W;

  logic [1:0]              rst_pipe;
  logic                    rst_sync_n;
  logic [3:0]              pin_raw, pin_s;
  logic                    en_s, sck_s, din_s, sel_s;
  logic [IDX_W-1:0]        rd_addr, reg_addr;
  logic [DATA_W-1:0]       rd_data, reg_wdata, ctrl_q;
  logic [NGAIN*DATA_W-1:0] gain_q;
  logic                    reg_we, dio_oe, dio_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign pin_raw = {grp_sel, ser_dio, ser_clk, ser_en};

  tw_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    (pin_raw),
    .q    (pin_s)
  );
  assign en_s  = pin_s[0];
  assign sck_s = pin_s[1];
  assign din_s = pin_s[2];
  assign sel_s = pin_s[3];

  tw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .SEL_BIT(SEL_BIT)) u_frame (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_s     (en_s),
    .sck_s    (sck_s),
    .din_s    (din_s),
    .sel_s    (sel_s),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .dio_oe   (dio_oe),
    .dio_out  (dio_out)
  );

  tw_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NGAIN(NGAIN)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (reg_we),
    .wr_idx (reg_addr),
    .wdata  (reg_wdata),
    .rd_idx (rd_addr),
    .rd_data(rd_data),
    .ctrl_q (ctrl_q),
    .gain_q (gain_q)
  );

  tw_decode #(.DATA_W(DATA_W), .NGAIN(NGAIN)) u_dec (
    .ctrl_q    (ctrl_q),
    .gain_q    (gain_q),
    .pwr_on    (pwr_on),
    .gain_range(gain_range),
    .wave_ch   (wave_ch),
    .gain_code (gain_code)
  );

  assign ser_dio = dio_oe ? dio_out : 1'bz;
endmodule

// File: rtl/tw_ctl_slave_chk.sv
module tw_ctl_slave_chk #(
  parameter int DATA_W = 8,
  parameter int NGAIN  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_s,
  input logic              sck_s,
  input logic              dio_oe,
  input logic              dio_out,
  input logic              reg_we,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [3:0]        rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              pwr_on,
  input logic [1:0]        wave_ch,
  input logic [DATA_W-1:0] gain_code
);
  // R1: control register only moves on a commit
  a_r1_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(ctrl_q));

  // R4: launched bit stays put while the serial clock is high
  a_r4_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dio_oe && $past(dio_oe) && sck_s && $past(sck_s)) |-> $stable(dio_out));

  // R5: the driver is on only inside a frame
  a_r5_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    dio_oe |-> $past(en_s));

  // R5: the driver is off once enable has dropped
  a_r5_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_s) |=> !dio_oe);

  // R6, R7: unmapped indices read zero
  a_r6_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr > 4'(NGAIN)) |-> (rd_data == '0));

  // R8: a commit only happens as enable falls
  a_r8_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (!en_s && $past(en_s)));

  // R11: no commit while the slave is driving
  a_r11_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !dio_oe);

  // R10: a nonzero gain code needs power and a channel
  a_r10_code_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_code != '0) |-> (pwr_on && (wave_ch != 2'b00)));
endmodule

bind tw_ctl_slave tw_ctl_slave_chk #(.DATA_W(DATA_W), .NGAIN(NGAIN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .en_s     (en_s),
  .sck_s    (sck_s),
  .dio_oe   (dio_oe),
  .dio_out  (dio_out),
  .reg_we   (reg_we),
  .ctrl_q   (ctrl_q),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .pwr_on   (pwr_on),
  .wave_ch  (wave_ch),
  .gain_code(gain_code)
);

// File: tb/tw_ctl_slave_tb.sv
module tw_ctl_slave_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       grp_sel, ser_en, ser_clk;
  logic       tb_oe, tb_bit;
  wire        ser_dio;
  logic       pwr_on;
  logic [1:0] gain_range, wave_ch;
  logic [7:0] gain_code;
  int         n_chk = 0;
  int         n_err = 0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  assign ser_dio = tb_oe ? tb_bit : 1'bz;

  tw_ctl_slave u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_sel   (grp_sel),
    .ser_en    (ser_en),
    .ser_clk   (ser_clk),
    .ser_dio   (ser_dio),
    .pwr_on    (pwr_on),
    .gain_range(gain_range),
    .wave_ch   (wave_ch),
    .gain_code (gain_code)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] a, input logic [7:0] d, input int nclk,
                      output logic [7:0] q);
    logic        rd;
    int          half;
    logic [15:0] w;
    rd   = a[7];
    half = rd ? 25 : 10;
    w    = {a, d};
    q    = '0;
    @(negedge clk);
    ser_en = 1'b1;
    tb_oe  = 1'b1;
    tb_bit = w[15];
    repeat (half) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      if (!(rd && i >= 8)) begin
        tb_oe  = 1'b1;
        tb_bit = (i < 16) ? w[15-i] : 1'b0;
      end
      repeat (half) @(negedge clk);
      if (rd && i >= 8 && i < 16) q[15-i] = ser_dio;
      ser_clk = 1'b1;
      if (rd && i == 7) begin
        @(negedge clk);
        tb_oe = 1'b0;
        repeat (half-1) @(negedge clk);
      end else begin
        repeat (half) @(negedge clk);
      end
      ser_clk = 1'b0;
    end
    repeat (half) @(negedge clk);
    ser_en = 1'b0;
    tb_oe  = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    xfer({1'b0, a[6:0]}, d, 16, dummy);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] q;
    xfer({1'b1, a[6:0]}, 8'h00, 16, q);
    check8(tag, q, exp);
  endtask

  task automatic outs_chk(input string tag, input logic p, input logic [1:0] r,
                          input logic [1:0] c, input logic [7:0] g);
    check8({tag, " pwr"}, {7'd0, pwr_on}, {7'd0, p});
    check8({tag, " range"}, {6'd0, gain_range}, {6'd0, r});
    check8({tag, " chan"}, {6'd0, wave_ch}, {6'd0, c});
    check8({tag, " code"}, gain_code, g);
  endtask

  task automatic t_reset;
    outs_chk("R1 reset", 1'b0, 2'b00, 2'b00, 8'h00);
    rd_chk("R1 ctrl", 8'h00, 8'h00);
    rd_chk("R1 gain1", 8'h01, 8'hFF);
    rd_chk("R1 gain2", 8'h02, 8'hFF);
    rd_chk("R1 gain3", 8'h03, 8'hFF);
  endtask

  task automatic t_write_read;
    wr(8'h01, 8'hA5);
    rd_chk("R2 R4 gain1 A5", 8'h01, 8'hA5);
    wr(8'h02, 8'h5A);
    rd_chk("R2 R4 gain2 5A", 8'h02, 8'h5A);
    wr(8'h03, 8'h81);
    rd_chk("R2 R4 gain3 81", 8'h03, 8'h81);
    rd_chk("R5 R11 gain1 after reads", 8'h01, 8'hA5);
  endtask

  task automatic t_group;
    wr(8'h11, 8'h3C);
    rd_chk("R3 low group ignores 11h", 8'h01, 8'hA5);
    grp_sel = 1'b1;
    repeat (10) @(negedge clk);
    wr(8'h12, 8'h66);
    wr(8'h01, 8'h00);
    rd_chk("R3 high group 12h", 8'h12, 8'h66);
    rd_chk("R3 high group 11h", 8'h11, 8'hA5);
    grp_sel = 1'b0;
    repeat (10) @(negedge clk);
    rd_chk("R3 back to low 02h", 8'h02, 8'h66);
  endtask

  task automatic t_test_regs;
    wr(8'h0E, 8'h77);
    wr(8'h0F, 8'hFF);
    rd_chk("R6 test 0Eh", 8'h0E, 8'h00);
    rd_chk("R6 test 0Fh", 8'h0F, 8'h00);
  endtask

  task automatic t_reserved;
    wr(8'h05, 8'h12);
    wr(8'h0D, 8'h34);
    rd_chk("R7 reserved 05h", 8'h05, 8'h00);
    rd_chk("R7 reserved 0Dh", 8'h0D, 8'h00);
    rd_chk("R7 gain3 intact", 8'h03, 8'h81);
    rd_chk("R7 ctrl intact", 8'h00, 8'h00);
  endtask

  task automatic t_bad_len;
    logic [7:0] q;
    xfer(8'h01, 8'h00, 12, q);
    rd_chk("R8 short frame", 8'h01, 8'hA5);
    xfer(8'h01, 8'h00, 18, q);
    rd_chk("R8 long frame", 8'h01, 8'hA5);
  endtask

  task automatic t_decode;
    wr(8'h02, 8'h22);
    wr(8'h00, 8'hC4);
    outs_chk("R9 R10 ch01", 1'b1, 2'b00, 2'b01, 8'hA5);
    wr(8'h00, 8'hD8);
    outs_chk("R9 R10 ch10", 1'b1, 2'b01, 2'b10, 8'h22);
    wr(8'h00, 8'hEC);
    outs_chk("R9 R10 ch11", 1'b1, 2'b10, 2'b11, 8'h81);
    wr(8'h00, 8'h9C);
    outs_chk("R9 R10 power 10", 1'b0, 2'b01, 2'b11, 8'h00);
    wr(8'h00, 8'hF3);
    outs_chk("R9 R10 no channel", 1'b1, 2'b11, 2'b00, 8'h00);
    rd_chk("R9 low bits kept", 8'h00, 8'hF3);
  endtask

  task automatic t_read_side;
    wr(8'h00, 8'hCC);
    rd_chk("R11 read ctrl", 8'h00, 8'hCC);
    outs_chk("R11 outputs after read", 1'b1, 2'b00, 2'b11, 8'h81);
  endtask

  initial begin
    rst_n   = 1'b0;
    grp_sel = 1'b0;
    ser_en  = 1'b0;
    ser_clk = 1'b0;
    tb_oe   = 1'b0;
    tb_bit  = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_write_read();
    t_group();
    t_test_regs();
    t_reserved();
    t_bad_len();
    t_decode();
    t_read_side();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule